// File: doc/BRIEF.md
# Cartridge Bus Cycle Sequencer

This block is a bus master for a game-cartridge edge connector. A host hands it one command at a time: a CPU-side read, a normal CPU write, a flash-style CPU write, a PPU-side read, a PPU-side write, or a compare against CPU or PPU memory. Each command carries a 16-bit start address and a byte count. The block then runs one bus cycle per byte and steps the address after each one. Before every byte it loads the high address bits into an external 8-bit latch over the shared data bus. It drives the low address byte on its own port. It sequences PHI2, R/W, /ROMSEL, /RD and /WR, and it controls the direction of the data bus.

When the last byte is done, the block parks the connector at the idle address 0x3FFF. That address deselects cartridge ROM and, on the PPU side, points into the palette area, so no tilemap RAM is enabled. The host supplies write and compare bytes through a take strobe. Read bytes come back with a valid pulse. Completion is a one-cycle done pulse that carries the compare result. The lengths of the PHI2 high and low phases are parameters counted in system clocks.

Top module: `cart_bus_seq`

## Requirements
- R1: While `cmd_ready` is high, the connector rests in the idle pattern: `phi2` low; `romsel_n`, `rw`, `rd_n`, `wr_n` and `latch_n` high; `bus_oe` low.
- R2: Before each byte, `latch_n` is low for exactly one clock. During that clock `bus_oe` is high and `bus_dout` is the latch byte: bit 7 = NOT A13, bit 6 = 0, bits 5..0 = A13..A8. A14 and A15 are not carried.
- R3: `romsel_n` goes low only when address bit 15 is 1. In normal CPU reads, CPU writes and CPU compares it goes low only while `phi2` is high.
- R4: A normal CPU write (`cmd_op`=1) runs in this order: R/W low with `phi2` low for one clock; then `phi2` high for PHI2_HI clocks with the data driven; then `phi2` low for PHI2_LO clocks. After that R/W is released.
- R5: A flash write (`cmd_op`=2) keeps `phi2` low throughout. R/W falls first. Then `romsel_n` falls (only when A15=1) with the data driven. `romsel_n` rises before R/W is released.
- R6: A PPU read (`cmd_op`=3 or 6) holds `rd_n` low for PHI2_HI clocks. A PPU write (`cmd_op`=4) holds `wr_n` low for PHI2_HI clocks. In both cases `phi2` stays low and `romsel_n` stays high.
- R7: For reads, `bus_oe` is low and `bus_dout` is 0xFF, with one settle clock before the active phase. `bus_din` is sampled on the last clock of the active phase. The sampled byte appears on `rd_byte` with a one-clock `rd_valid` pulse (`cmd_op`=0 CPU read, 3 PPU read).
- R8: A command runs `cmd_len` byte cycles at consecutive addresses, wrapping at 16 bits. `wr_take` pulses once per byte for write and compare commands, and `wr_byte` is captured in that clock.
- R9: After the final byte, the latch is reloaded with 0x3F and `addr_lo` returns to 0xFF. `done` then pulses for one clock.
- R10: A compare (`cmd_op`=5 CPU, 6 PPU) checks each read byte against the taken host byte. At the first difference it stops without further byte cycles, parks, and reports `mismatch`=1 with `done`. A command that ends without any difference reports 0.
- R11: Every `phi2` high phase lasts exactly PHI2_HI clocks.
- R12: A `cmd_len` of 0, or `cmd_op`=7, runs no byte cycle. It only parks and pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, accepts command |
| cmd_op | input | 3 | Command code (see R4-R12) |
| cmd_addr | input | 16 | Start address |
| cmd_len | input | LEN_W | Byte count |
| wr_byte | input | 8 | Host byte for write or compare |
| wr_take | output | 1 | `wr_byte` captured this clock |
| rd_byte | output | 8 | Read result |
| rd_valid | output | 1 | `rd_byte` valid pulse |
| done | output | 1 | Command finished pulse |
| mismatch | output | 1 | Compare result, valid with `done` |
| addr_lo | output | 8 | Address bits 7..0 |
| bus_dout | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | 8 | Data bus input value |
| phi2 | output | 1 | CPU phase-2 clock |
| rw | output | 1 | CPU read/write, low = write |
| romsel_n | output | 1 | Cartridge ROM select, active low |
| rd_n | output | 1 | PPU read strobe, active low |
| wr_n | output | 1 | PPU write strobe, active low |
| latch_n | output | 1 | High-address latch strobe, latches on rise |

## Verification
The assertions watch the connector on every clock. They cover the idle pattern while ready, the bus being driven during every latch strobe, the tie between /ROMSEL and PHI2, R/W falling and rising on the correct side of chip select, PPU strobes never overlapping PHI2, a 0xFF float level whenever the bus is released, the parked address at done, and the exact PHI2 high length. Whether the right bytes reach the right addresses can only be shown by the bench's scenarios, which run against a cartridge model that latches the high byte and answers reads. Those scenarios also cover the latch encoding around the A13 and A15 boundaries, burst stepping, compare aborts at the first, last or no byte, and zero-length commands.

// File: rtl/cart_bus_seq.sv
module cart_bus_seq #(
  parameter int PHI2_HI = 6,
  parameter int PHI2_LO = 6,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             done,
  output logic             mismatch,
  output logic [7:0]       addr_lo,
  output logic [7:0]       bus_dout,
  output logic             bus_oe,
  input  logic [7:0]       bus_din,
  output logic             phi2,
  output logic             rw,
  output logic             romsel_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             latch_n
);
  localparam int PMAX = (PHI2_HI > PHI2_LO) ? PHI2_HI : PHI2_LO;
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [2:0] OP_CRD = 3'd0, OP_CWR = 3'd1, OP_FWR = 3'd2, OP_PRD = 3'd3,
                         OP_PWR = 3'd4, OP_CCMP = 3'd5, OP_PCMP = 3'd6, OP_NOP = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_LAT, S_SET, S_ACT, S_REC, S_PLAT, S_DONE} st_t;

  st_t              state;
  logic [2:0]       op;
  logic [15:0]      addr;
  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    cnt;
  logic [7:0]       wbyte;
  logic             mism;

  wire cyc      = (state == S_SET) || (state == S_ACT) || (state == S_REC);
  wire plat     = (state == S_PLAT);
  wire lat      = (state == S_LAT) || plat;
  wire act      = (state == S_ACT);
  wire op_cpu   = (op == OP_CRD) || (op == OP_CWR) || (op == OP_CCMP);
  wire op_cpuw  = (op == OP_CWR) || (op == OP_FWR);
  wire op_wr    = op_cpuw || (op == OP_PWR);
  wire op_cmp   = (op == OP_CCMP) || (op == OP_PCMP);
  wire op_prd   = (op == OP_PRD) || (op == OP_PCMP);
  wire sel_rom  = addr[15] && (op_cpu || (op == OP_FWR));
  wire last_act = act && (cnt == CW'(PHI2_HI - 1));
  wire last_rec = (state == S_REC) && (cnt == CW'(PHI2_LO - 1));
  wire miss     = bus_din != wbyte;

  wire       lat_a13 = plat ? 1'b1 : addr[13];
  wire [5:0] lat_hi6 = plat ? 6'h3F : addr[13:8];

  assign cmd_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign mismatch  = mism;
  assign wr_take   = (state == S_LAT) && (op_wr || op_cmp);
  assign latch_n   = !lat;
  assign bus_oe    = lat || (cyc && op_wr);
  assign bus_dout  = lat ? {~lat_a13, 1'b0, lat_hi6} : (cyc && op_wr) ? wbyte : 8'hFF;
  assign addr_lo   = (cyc || state == S_LAT) ? addr[7:0] : 8'hFF;
  assign phi2      = act && op_cpu;
  assign romsel_n  = !(act && sel_rom);
  assign rw        = !(cyc && op_cpuw);
  assign rd_n      = !(act && op_prd);
  assign wr_n      = !(act && op == OP_PWR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op       <= OP_NOP;
      addr     <= 16'h3FFF;
      remain   <= '0;
      cnt      <= '0;
      wbyte    <= 8'h00;
      mism     <= 1'b0;
      rd_byte  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op     <= cmd_op;
          addr   <= cmd_addr;
          remain <= cmd_len;
          mism   <= 1'b0;
          state  <= (cmd_len == '0 || cmd_op == OP_NOP) ? S_PLAT : S_LAT;
        end
        S_LAT: begin
          wbyte <= wr_byte;
          cnt   <= '0;
          state <= S_SET;
        end
        S_SET: state <= S_ACT;
        S_ACT: begin
          if (last_act) begin
            cnt <= '0;
            if (op_cmp && miss) begin
              mism  <= 1'b1;
              state <= S_PLAT;
            end else begin
              if (!op_wr && !op_cmp) begin
                rd_byte  <= bus_din;
                rd_valid <= 1'b1;
              end
              state <= S_REC;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REC: begin
          if (last_rec) begin
            if (remain == LEN_W'(1)) begin
              state <= S_PLAT;
            end else begin
              remain <= remain - 1'b1;
              addr   <= addr + 16'd1;
              state  <= S_LAT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PLAT: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cart_bus_seq_chk.sv
module cart_bus_seq_chk #(
  parameter int PHI2_HI = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       done,
  input logic       rd_valid,
  input logic [7:0] addr_lo,
  input logic [7:0] bus_dout,
  input logic       bus_oe,
  input logic       phi2,
  input logic       rw,
  input logic       romsel_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       latch_n
);
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_len <= '0;
    else if (phi2) hi_len <= hi_len + 16'd1;
    else hi_len <= '0;
  end

  assert_idle_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!phi2 && romsel_n && rw && rd_n && wr_n && latch_n && !bus_oe));

  assert_latch_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |-> (bus_oe && !bus_dout[6] && phi2 == 1'b0));

  assert_romsel_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!romsel_n && rw) |-> phi2);

  assert_rw_falls_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rw) |-> (romsel_n && !phi2));

  assert_rw_rises_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw) |-> ($past(romsel_n) && !phi2));

  assert_ppu_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!phi2 && romsel_n && (rd_n || wr_n)));

  assert_float_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == 8'hFF));

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (addr_lo == 8'hFF && latch_n && !phi2 && romsel_n && rw));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_phi2_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi2 && hi_len != 16'd0) |-> (hi_len == 16'(PHI2_HI)));
endmodule

bind cart_bus_seq cart_bus_seq_chk #(.PHI2_HI(PHI2_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .rd_valid(rd_valid),
  .addr_lo(addr_lo), .bus_dout(bus_dout), .bus_oe(bus_oe), .phi2(phi2), .rw(rw),
  .romsel_n(romsel_n), .rd_n(rd_n), .wr_n(wr_n), .latch_n(latch_n)
);

// File: tb/cart_bus_seq_tb_top.sv
module cart_bus_seq_tb_top;
  localparam int HI = 3;
  localparam int LO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [15:0] cmd_addr = 16'h0;
  logic [7:0] cmd_len = 8'd0;
  logic [7:0] wr_byte = 8'h00;
  logic wr_take, rd_valid, done, mismatch, bus_oe;
  logic [7:0] rd_byte, addr_lo, bus_dout;
  logic [7:0] bus_din = 8'h00;
  logic phi2, rw, romsel_n, rd_n, wr_n, latch_n;

  always #5 clk = ~clk;

  cart_bus_seq #(.PHI2_HI(HI), .PHI2_LO(LO), .LEN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_byte(wr_byte),
    .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid), .done(done),
    .mismatch(mismatch), .addr_lo(addr_lo), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .phi2(phi2), .rw(rw), .romsel_n(romsel_n), .rd_n(rd_n),
    .wr_n(wr_n), .latch_n(latch_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0]  wbuf [16];
  logic [7:0]  rbuf [16];
  logic [16:0] wl_key [16];
  logic [7:0]  wl_dat [16];
  logic [7:0]  lat_log [16];
  int rn, wn, nlat, widx, takes, nstrobe, nphi;
  logic [7:0] hi_q = 8'h00;
  logic [7:0] lat_pend = 8'h00;
  bit take_seen = 0;
  logic p_phi2 = 0, p_romsel = 1, p_wr = 1, p_rd = 1, p_lat = 1;
  int phi_len = 0, rd_len = 0, wr_len = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hib(input logic [15:0] a);
    return {~a[13], 1'b0, a[13:8]};
  endfunction

  function automatic logic [16:0] keyof(input logic [15:0] a, input bit cpu);
    return {cpu ? a[15] : 1'b0, hib(a), a[7:0]};
  endfunction

  function automatic logic [7:0] mdl(input logic [16:0] k, input bit ppu);
    return k[7:0] ^ {k[14:8], k[16]} ^ (ppu ? 8'hA5 : 8'h3C);
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (take_seen) begin widx++; take_seen = 0; end
      wr_byte = wbuf[widx % 16];
      if (wr_take) begin take_seen = 1; takes++; end
      if (!latch_n) begin
        lat_pend = bus_dout;
        check(bus_oe, "R2 latch bus driven", bus_oe, 1);
      end
      if (!p_lat && latch_n) begin
        hi_q = lat_pend;
        if (nlat < 16) lat_log[nlat] = lat_pend;
        nlat++;
      end
      if (phi2) phi_len++;
      else if (p_phi2) begin check(phi_len == HI, "R11 phi2 high length", phi_len, HI); phi_len = 0; end
      if (!rd_n) rd_len++;
      else if (!p_rd) begin check(rd_len == HI, "R6 rd_n low length", rd_len, HI); rd_len = 0; end
      if (!wr_n) wr_len++;
      else if (!p_wr) begin check(wr_len == HI, "R6 wr_n low length", wr_len, HI); wr_len = 0; end
      if (phi2 && !p_phi2) nphi++;
      if ((phi2 && !p_phi2 && rw) || (!rd_n && p_rd)) nstrobe++;
      if ((phi2 && !p_phi2 && !rw) || (!romsel_n && p_romsel && !phi2) || (!wr_n && p_wr)) begin
        if (wn < 16) begin
          wl_key[wn] = {(!wr_n) ? 1'b0 : !romsel_n, hi_q, addr_lo};
          wl_dat[wn] = bus_dout;
        end
        wn++;
      end
      if (!rd_n) bus_din = mdl({1'b0, hi_q, addr_lo}, 1'b1);
      else if (phi2) bus_din = mdl({!romsel_n, hi_q, addr_lo}, 1'b0);
      else bus_din = 8'h00;
      if (rd_valid) begin
        if (rn < 16) rbuf[rn] = rd_byte;
        rn++;
      end
      p_phi2 = phi2; p_romsel = romsel_n; p_wr = wr_n; p_rd = rd_n; p_lat = latch_n;
    end
  end

  task automatic check_idle(input string tag);
    check(cmd_ready && !phi2 && romsel_n && rw && rd_n && wr_n && latch_n && !bus_oe,
          tag, {cmd_ready, phi2, romsel_n, rw, rd_n, wr_n, latch_n, bus_oe}, 8'b10111110);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] a, input int len, input int bad);
    bit cpu, ppu;
    bit got_mis;
    int t;
    int exp_n;
    bit exp_mis;
    cpu = (op == 3'd0 || op == 3'd1 || op == 3'd2 || op == 3'd5);
    ppu = (op == 3'd3 || op == 3'd4 || op == 3'd6);
    for (int i = 0; i < 16; i++) begin
      if (op == 3'd5 || op == 3'd6) begin
        wbuf[i] = mdl(keyof(a + 16'(i), cpu), ppu);
        if (i == bad) wbuf[i] = wbuf[i] ^ 8'h01;
      end else begin
        wbuf[i] = 8'($urandom);
      end
    end
    @(negedge clk);
    rn = 0; wn = 0; nlat = 0; widx = 0; takes = 0; nstrobe = 0; nphi = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_len = 8'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(done == 1'b1, "R9 done reached", done, 1);
    got_mis = mismatch;
    @(negedge clk);
    check_idle("R1 idle after command");
    check(hi_q == 8'h3F && addr_lo == 8'hFF, "R9 parked at 3FFF", {hi_q, addr_lo}, 16'h3FFF);
    if (len == 0 || op == 3'd7) begin
      check(nlat == 1 && nphi == 0 && wn == 0 && nstrobe == 0 && takes == 0,
            "R12 no byte cycle", nlat + nphi + wn + nstrobe + takes, 1);
    end else begin
      if (nlat > 0) check(lat_log[0] == hib(a), "R2 latch byte", lat_log[0], hib(a));
      case (op)
        3'd0, 3'd3: begin
          check(rn == len, "R7 read count", rn, len);
          for (int i = 0; i < len && i < 16; i++)
            check(rbuf[i] == mdl(keyof(a + 16'(i), cpu), ppu), op == 3'd0 ? "R3 R8 cpu read data" : "R6 R8 ppu read data",
                  rbuf[i], mdl(keyof(a + 16'(i), cpu), ppu));
          check(nphi == (op == 3'd0 ? len : 0), "R6 phi2 pulses", nphi, op == 3'd0 ? len : 0);
        end
        3'd1, 3'd4: begin
          check(wn == len && takes == len, "R8 write count", wn, len);
          for (int i = 0; i < len && i < 16; i++)
            check(wl_key[i] == keyof(a + 16'(i), cpu) && wl_dat[i] == wbuf[i],
                  op == 3'd1 ? "R4 cpu write" : "R6 ppu write", {wl_key[i], wl_dat[i]}, {keyof(a + 16'(i), cpu), wbuf[i]});
        end
        3'd2: begin
          exp_n = 0;
          for (int i = 0; i < len; i++) begin
            logic [15:0] ai;
            ai = a + 16'(i);
            if (ai[15]) begin
              if (exp_n < 16)
                check(wl_key[exp_n] == keyof(ai, 1'b1) && wl_dat[exp_n] == wbuf[i], "R5 flash write",
                      {wl_key[exp_n], wl_dat[exp_n]}, {keyof(ai, 1'b1), wbuf[i]});
              exp_n++;
            end
          end
          check(wn == exp_n && nphi == 0, "R5 flash strobes", wn, exp_n);
        end
        default: begin
          exp_mis = (bad < len);
          exp_n = exp_mis ? bad + 1 : len;
          check(got_mis == exp_mis, "R10 mismatch flag", got_mis, exp_mis);
          check(nstrobe == exp_n && takes == exp_n, "R10 bytes before abort", nstrobe, exp_n);
          check(rn == 0, "R10 no rd_valid", rn, 0);
        end
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check_idle("R1 reset state");
    check(addr_lo == 8'hFF && !done && !rd_valid && !wr_take, "R1 reset outputs", addr_lo, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    run_cmd(3'd0, 16'h8000, 1, 99);
    run_cmd(3'd0, 16'h6000, 2, 99);
    run_cmd(3'd0, 16'h7FFF, 2, 99);
    run_cmd(3'd1, 16'hC123, 3, 99);
    run_cmd(3'd2, 16'hD555, 2, 99);
    run_cmd(3'd2, 16'h7FFF, 3, 99);
    run_cmd(3'd4, 16'h1FFF, 3, 99);
    run_cmd(3'd3, 16'h0FFE, 4, 99);
    run_cmd(3'd5, 16'h9000, 4, 0);
    run_cmd(3'd5, 16'h9000, 4, 3);
    run_cmd(3'd6, 16'h0100, 4, 99);
    run_cmd(3'd0, 16'h1234, 0, 99);
    run_cmd(3'd7, 16'h1234, 5, 99);
    run_cmd(3'd3, 16'hFFFF, 2, 99);

    for (int n = 0; n < 60; n++) begin
      logic [2:0] op;
      int len;
      op = 3'($urandom_range(0, 7));
      len = $urandom_range(0, 6);
      run_cmd(op, 16'($urandom), len, $urandom_range(0, len));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule